// File: doc/BRIEF.md
# SAR ADC Multi-Channel Scan Controller

This block is the digital half of a successive-approximation converter serving up to eight analog inputs through one shared multiplexer. For each enabled channel it selects the mux input, spends one cycle sampling, then runs a binary search from the most significant bit downwards. Each cycle it drives a trial code to the DAC and reads back a single comparator bit. Finished codes land in a per-channel result register, left-aligned in a 10-bit field. A per-channel comparison against a programmable threshold produces a flag.

A scan starts on a software pulse or on a chosen edge of one of several trigger lines. One trigger line can be the scan-done pulse of another instance, so converters can be chained. Single mode stops after the highest enabled channel. Continuous mode re-arms automatically. All configuration is written into a staging copy. It reaches the converting logic only through an explicit update request, and that request is deferred to the next scan boundary when a scan is running. A power-down input halts everything and parks the analog interface.

Top module: `sar_scan_ctrl`

## Requirements
- R1: A conversion at resolution N yields the input value truncated to its top N bits of a 10-bit scale. Bits below the resolution read as zero, as seen on `rd_data` for the selected channel.
- R2: Each enabled channel occupies exactly 1 + N cycles: one sample cycle with `sample_en` high, then N bit cycles. `busy` stays high for (enabled channels) × (1 + N) cycles per scan.
- R3: Enabled channels are converted in ascending index order. `mux_sel` holds the channel number while `sample_en` is high, and only channels whose bit is set in the active enable mask are visited.
- R4: In single mode the scan stops after the last enabled channel. `scan_done` is high for exactly one cycle, in the first cycle in which `busy` is low.
- R5: In continuous mode a new scan begins after one idle cycle, so `scan_done` pulses repeat every (enabled channels) × (1 + N) + 1 cycles. Clearing the mode through an update stops the repetition at the following scan end.
- R6: Trigger source code 0 selects no hardware trigger, and code k (1..4) selects `trig_in[k-1]`. Edge select 0 starts on a rising edge and 1 on a falling edge. Unselected lines have no effect, while `sw_start` always starts an idle block.
- R7: Starts and trigger edges arriving while `busy` is high are ignored. Each scan yields one `scan_done` pulse.
- R8: After each conversion of a channel, its `cmp_flags` bit is set to (result ≥ threshold) when that channel's direction bit is 1, and to (result < threshold) when it is 0. The threshold is on the same 10-bit left-aligned scale.
- R9: Staging writes have no effect on conversions until `upd_req` is given. A request made while idle is committed at the next clock edge.
- R10: An `upd_req` made during a scan sets `upd_pending`. That scan still uses the old configuration. The commit happens at the scan's final edge, which also clears `upd_pending`.
- R11: A staged resolution below 2 is treated as 2, and one above 10 is treated as 10.
- R12: While `power_down` is high, `busy`, `sample_en` and `dac_code` are zero from the next cycle on and starts are ignored. A running continuous scan does not resume when `power_down` falls.
- R13: Result registers keep their value for channels not converted in a scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stg_we | input | 1 | Write strobe for the staged global fields |
| stg_en_mask | input | 8 | Staged channel enable mask |
| stg_res_bits | input | 4 | Staged resolution in bits (clamped to 2..10) |
| stg_continuous | input | 1 | Staged scan mode, 1 = continuous |
| stg_trig_src | input | 3 | Staged trigger source code |
| stg_trig_fall | input | 1 | Staged trigger edge, 1 = falling |
| stg_cmp_we | input | 1 | Write strobe for one channel's staged threshold |
| stg_cmp_ch | input | 3 | Channel addressed by the threshold write |
| stg_cmp_val | input | 10 | Staged threshold, left-aligned scale |
| stg_cmp_ge | input | 1 | Staged flag direction, 1 = flag when result ≥ threshold |
| upd_req | input | 1 | Request to copy staging into the active set |
| upd_pending | output | 1 | A deferred update waits for the scan boundary |
| sw_start | input | 1 | Software scan start |
| trig_in | input | 4 | Hardware trigger lines |
| power_down | input | 1 | Halts conversion and idles the analog interface |
| mux_sel | output | 3 | Analog multiplexer channel |
| sample_en | output | 1 | Sample phase of the current channel |
| dac_code | output | 10 | Trial code to the DAC, zero outside bit cycles |
| cmp_in | input | 1 | Comparator: 1 when input ≥ DAC level |
| busy | output | 1 | A scan is in progress |
| scan_done | output | 1 | One-cycle end-of-scan pulse |
| rd_ch | input | 3 | Result read channel select |
| rd_data | output | 10 | Result of the selected channel |
| cmp_flags | output | 8 | Per-channel compare flags |

## Verification
The bench builds the block with its defaults: eight channels, a 10-bit result field, a minimum of 2 bits and four trigger lines. These values give every resolution from 2 to 10 bits, every mask pattern of the full channel set, and each trigger code, including the out-of-range codes beyond the four lines. An ideal comparator model closes the loop, so random input levels, masks, thresholds and directions expose truncation, ordering and flag errors at every resolution.

// File: rtl/sar_scan_pkg.sv
`timescale 1ns/1ps
// Shared types for the SAR scan controller.
package sar_scan_pkg;
    // Scan sequencer states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_BITS   = 2'd2
    } scan_st_t;
endpackage

// File: rtl/sar_cfg_shadow.sv
`timescale 1ns/1ps
// Staging and active configuration sets.
// Writes go to the staging copy; a commit copies everything into the active
// copy, but only when the sequencer reports a scan boundary. A request made
// away from a boundary is held pending. Assumes boundary is high while idle.
module sar_cfg_shadow #(
    parameter int NUM_CH   = 8,
    parameter int DW       = 10,
    parameter int MIN_BITS = 2,
    parameter int CH_W     = 3,
    parameter int RES_W    = 4,
    parameter int TSEL_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       stg_we,
    input  logic [NUM_CH-1:0]          stg_en_mask,
    input  logic [RES_W-1:0]           stg_res_bits,
    input  logic                       stg_continuous,
    input  logic [TSEL_W-1:0]          stg_trig_src,
    input  logic                       stg_trig_fall,
    input  logic                       stg_cmp_we,
    input  logic [CH_W-1:0]            stg_cmp_ch,
    input  logic [DW-1:0]              stg_cmp_val,
    input  logic                       stg_cmp_ge,
    input  logic                       upd_req,
    input  logic                       boundary,
    output logic [NUM_CH-1:0]          act_en_mask,
    output logic [RES_W-1:0]           act_res,
    output logic                       act_continuous,
    output logic [TSEL_W-1:0]          act_trig_src,
    output logic                       act_trig_fall,
    output logic [NUM_CH-1:0][DW-1:0]  act_cmp_val,
    output logic [NUM_CH-1:0]          act_cmp_ge,
    output logic                       upd_pending
);
    logic [NUM_CH-1:0]         s_mask;
    logic [RES_W-1:0]          s_res;
    logic                      s_cont;
    logic [TSEL_W-1:0]         s_src;
    logic                      s_fall;
    logic [NUM_CH-1:0][DW-1:0] s_cval;
    logic [NUM_CH-1:0]         s_cge;
    logic                      commit;

    function automatic logic [RES_W-1:0] clamp_res(input logic [RES_W-1:0] v);
        if (v < RES_W'(MIN_BITS))
            return RES_W'(MIN_BITS);
        else if (v > RES_W'(DW))
            return RES_W'(DW);
        else
            return v;
    endfunction

    assign commit = (upd_req | upd_pending) & boundary;

    // Staged global fields, resolution clamped on entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_mask <= '0;
            s_res  <= RES_W'(DW);
            s_cont <= 1'b0;
            s_src  <= '0;
            s_fall <= 1'b0;
        end else if (stg_we) begin
            s_mask <= stg_en_mask;
            s_res  <= clamp_res(stg_res_bits);
            s_cont <= stg_continuous;
            s_src  <= stg_trig_src;
            s_fall <= stg_trig_fall;
        end
    end

    // Staged per-channel thresholds and directions
    for (genvar g = 0; g < NUM_CH; g++) begin : g_cmp_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_cval[g] <= '0;
                s_cge[g]  <= 1'b0;
            end else if (stg_cmp_we && stg_cmp_ch == CH_W'(g)) begin
                s_cval[g] <= stg_cmp_val;
                s_cge[g]  <= stg_cmp_ge;
            end
        end
    end

    // Deferred-update flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            upd_pending <= 1'b0;
        else if (commit)
            upd_pending <= 1'b0;
        else if (upd_req)
            upd_pending <= 1'b1;
    end

    // Active set, loaded only on commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_en_mask    <= '0;
            act_res        <= RES_W'(DW);
            act_continuous <= 1'b0;
            act_trig_src   <= '0;
            act_trig_fall  <= 1'b0;
            act_cmp_val    <= '0;
            act_cmp_ge     <= '0;
        end else if (commit) begin
            act_en_mask    <= s_mask;
            act_res        <= s_res;
            act_continuous <= s_cont;
            act_trig_src   <= s_src;
            act_trig_fall  <= s_fall;
            act_cmp_val    <= s_cval;
            act_cmp_ge     <= s_cge;
        end
    end

    // A pending update is taken at the first boundary
    p_pending_commits_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pending && boundary) |=> !upd_pending);

    // Active configuration never moves inside a scan
    p_active_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> ($stable(act_res) && $stable(act_en_mask) && $stable(act_continuous)));

    // Active resolution always within the legal range
    p_res_in_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (act_res >= RES_W'(MIN_BITS)) && (act_res <= RES_W'(DW)));
endmodule

// File: rtl/sar_trig_sel.sv
`timescale 1ns/1ps
// Trigger source selection and edge detection.
// Code 0 selects nothing; code k selects line k-1. The previous level of
// every line is registered each cycle, so switching source never invents an
// edge from stale history. Assumes trigger lines are already synchronous.
module sar_trig_sel #(
    parameter int NUM_TRIG = 4,
    parameter int TSEL_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TRIG-1:0]  trig_in,
    input  logic [TSEL_W-1:0]    src,
    input  logic                 fall,
    output logic                 hit
);
    logic [NUM_TRIG-1:0] prev;

    // Previous level of each trigger line
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev <= '0;
        else
            prev <= trig_in;
    end

    // Edge of the selected line in the selected polarity
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (src == TSEL_W'(i + 1))
                hit = fall ? (prev[i] & ~trig_in[i]) : (trig_in[i] & ~prev[i]);
        end
    end

    // A hit always coincides with a level change on some line
    p_hit_is_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (trig_in != prev));
endmodule

// File: rtl/sar_bit_engine.sv
`timescale 1ns/1ps
// Successive-approximation register.
// load clears the code and places the trial bit at the MSB; each step keeps
// or drops the trial bit per the comparator and moves it one place down.
// last marks the trial at the lowest bit of the active resolution.
// Assumes res is in range and constant during a conversion.
module sar_bit_engine #(
    parameter int DW    = 10,
    parameter int RES_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [RES_W-1:0]  res,
    input  logic              cmp_in,
    output logic [DW-1:0]     trial_code,
    output logic [DW-1:0]     conv_next,
    output logic              last
);
    logic [DW-1:0] code;
    logic [DW-1:0] trial;
    logic [DW-1:0] lsb_one;

    assign lsb_one    = DW'(1) << (DW - int'(res));
    assign trial_code = code | trial;
    assign conv_next  = cmp_in ? (code | trial) : code;
    assign last       = (trial == lsb_one);

    // Binary search registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code  <= '0;
            trial <= '0;
        end else if (load) begin
            code  <= '0;
            trial <= {1'b1, {(DW-1){1'b0}}};
        end else if (step) begin
            code  <= conv_next;
            trial <= trial >> 1;
        end
    end

    // Exactly one trial bit while stepping
    p_trial_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ($countones(trial) == 1));

    // No decided bit below the current trial position
    p_low_bits_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> ((code & (trial - DW'(1))) == '0));
endmodule

// File: rtl/sar_scan_ctrl.sv
`timescale 1ns/1ps
// Multi-channel SAR scan controller (top).
// Sequences the enabled channels in ascending order: one sample cycle, then
// N bit cycles per channel. Stores results and compare flags per channel and
// arbitrates starts, triggers, continuous re-arm and power-down.
// Assumes an external comparator returns cmp_in = (input >= dac_code) within
// the same cycle.
module sar_scan_ctrl
    import sar_scan_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int DW       = 10,
    parameter int MIN_BITS = 2,
    parameter int NUM_TRIG = 4,
    parameter int CH_W     = $clog2(NUM_CH),
    parameter int RES_W    = $clog2(DW + 1),
    parameter int TSEL_W   = $clog2(NUM_TRIG + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stg_we,
    input  logic [NUM_CH-1:0]    stg_en_mask,
    input  logic [RES_W-1:0]     stg_res_bits,
    input  logic                 stg_continuous,
    input  logic [TSEL_W-1:0]    stg_trig_src,
    input  logic                 stg_trig_fall,
    input  logic                 stg_cmp_we,
    input  logic [CH_W-1:0]      stg_cmp_ch,
    input  logic [DW-1:0]        stg_cmp_val,
    input  logic                 stg_cmp_ge,
    input  logic                 upd_req,
    output logic                 upd_pending,
    input  logic                 sw_start,
    input  logic [NUM_TRIG-1:0]  trig_in,
    input  logic                 power_down,
    output logic [CH_W-1:0]      mux_sel,
    output logic                 sample_en,
    output logic [DW-1:0]        dac_code,
    input  logic                 cmp_in,
    output logic                 busy,
    output logic                 scan_done,
    input  logic [CH_W-1:0]      rd_ch,
    output logic [DW-1:0]        rd_data,
    output logic [NUM_CH-1:0]    cmp_flags
);
    scan_st_t                  state;
    logic [CH_W-1:0]           cur_ch;
    logic                      rearm;
    logic                      done_q;
    logic [DW-1:0]             res_q [NUM_CH];

    logic [NUM_CH-1:0]         act_en_mask;
    logic [RES_W-1:0]          act_res;
    logic                      act_continuous;
    logic [TSEL_W-1:0]         act_trig_src;
    logic                      act_trig_fall;
    logic [NUM_CH-1:0][DW-1:0] act_cmp_val;
    logic [NUM_CH-1:0]         act_cmp_ge;

    logic                      trig_hit;
    logic                      start_req;
    logic                      go_sample;
    logic                      store;
    logic                      scan_end;
    logic                      boundary;
    logic [CH_W-1:0]           first_ch;
    logic [CH_W-1:0]           next_ch;
    logic                      has_next;
    logic [DW-1:0]             trial_code;
    logic [DW-1:0]             conv_next;
    logic                      eng_last;

    sar_cfg_shadow #(
        .NUM_CH(NUM_CH), .DW(DW), .MIN_BITS(MIN_BITS),
        .CH_W(CH_W), .RES_W(RES_W), .TSEL_W(TSEL_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .stg_we(stg_we), .stg_en_mask(stg_en_mask), .stg_res_bits(stg_res_bits),
        .stg_continuous(stg_continuous), .stg_trig_src(stg_trig_src),
        .stg_trig_fall(stg_trig_fall), .stg_cmp_we(stg_cmp_we),
        .stg_cmp_ch(stg_cmp_ch), .stg_cmp_val(stg_cmp_val), .stg_cmp_ge(stg_cmp_ge),
        .upd_req(upd_req), .boundary(boundary),
        .act_en_mask(act_en_mask), .act_res(act_res),
        .act_continuous(act_continuous), .act_trig_src(act_trig_src),
        .act_trig_fall(act_trig_fall), .act_cmp_val(act_cmp_val),
        .act_cmp_ge(act_cmp_ge), .upd_pending(upd_pending)
    );

    sar_trig_sel #(.NUM_TRIG(NUM_TRIG), .TSEL_W(TSEL_W)) u_trig (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .src(act_trig_src), .fall(act_trig_fall), .hit(trig_hit)
    );

    sar_bit_engine #(.DW(DW), .RES_W(RES_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .load(go_sample), .step(state == ST_BITS),
        .res(act_res), .cmp_in(cmp_in), .trial_code(trial_code),
        .conv_next(conv_next), .last(eng_last)
    );

    // Lowest enabled channel, and lowest enabled channel above the current one
    always_comb begin
        first_ch = '0;
        next_ch  = '0;
        has_next = 1'b0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (act_en_mask[i]) begin
                first_ch = CH_W'(i);
                if (i > int'(cur_ch)) begin
                    next_ch  = CH_W'(i);
                    has_next = 1'b1;
                end
            end
        end
    end

    // Scan start, channel hand-over and scan-boundary decode
    always_comb begin
        start_req = (sw_start | trig_hit | (rearm & act_continuous))
                    & ~power_down & (|act_en_mask);
        store     = (state == ST_BITS) & eng_last & ~power_down;
        scan_end  = store & ~has_next;
        go_sample = ~power_down & (((state == ST_IDLE) & start_req) | (store & has_next));
        boundary  = (state == ST_IDLE) | scan_end;
    end

    // Scan sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cur_ch <= '0;
            rearm  <= 1'b0;
            done_q <= 1'b0;
        end else if (power_down) begin
            state  <= ST_IDLE;
            rearm  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    rearm <= 1'b0;
                    if (start_req) begin
                        state  <= ST_SAMPLE;
                        cur_ch <= first_ch;
                    end
                end
                ST_SAMPLE: state <= ST_BITS;
                ST_BITS: begin
                    if (eng_last) begin
                        if (has_next) begin
                            state  <= ST_SAMPLE;
                            cur_ch <= next_ch;
                        end else begin
                            state  <= ST_IDLE;
                            done_q <= 1'b1;
                            rearm  <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Per-channel result and compare flag, written on the final bit
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q[g]     <= '0;
                cmp_flags[g] <= 1'b0;
            end else if (store && cur_ch == CH_W'(g)) begin
                res_q[g]     <= conv_next;
                cmp_flags[g] <= act_cmp_ge[g] ? (conv_next >= act_cmp_val[g])
                                              : (conv_next <  act_cmp_val[g]);
            end
        end
    end

    assign mux_sel   = cur_ch;
    assign sample_en = (state == ST_SAMPLE);
    assign dac_code  = (state == ST_BITS) ? trial_code : '0;
    assign busy      = (state != ST_IDLE);
    assign scan_done = done_q;
    assign rd_data   = res_q[rd_ch];

    // Power-down parks the analog interface on the next cycle
    p_pd_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        power_down |=> (!busy && !sample_en && dac_code == '0));

    // Done is a single-cycle pulse outside the busy window
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> (!busy ##1 !scan_done));

    // Only enabled channels are sampled
    p_mux_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> act_en_mask[mux_sel]);

    // Hand-over goes to a higher channel
    p_ascending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (store && has_next) |=> (sample_en && mux_sel > $past(mux_sel)));

    // Sample phase lasts one cycle and keeps the channel
    p_sample_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !power_down) |=> (!sample_en && busy && $stable(mux_sel)));
endmodule

// File: tb/sar_scan_ctrl_test.sv
`timescale 1ns/1ps
module sar_scan_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stg_we = 0;
    logic [7:0]  stg_en_mask = 0;
    logic [3:0]  stg_res_bits = 0;
    logic        stg_continuous = 0;
    logic [2:0]  stg_trig_src = 0;
    logic        stg_trig_fall = 0;
    logic        stg_cmp_we = 0;
    logic [2:0]  stg_cmp_ch = 0;
    logic [9:0]  stg_cmp_val = 0;
    logic        stg_cmp_ge = 0;
    logic        upd_req = 0;
    logic        upd_pending;
    logic        sw_start = 0;
    logic [3:0]  trig_in = 0;
    logic        power_down = 0;
    logic [2:0]  mux_sel;
    logic        sample_en;
    logic [9:0]  dac_code;
    logic        cmp_in;
    logic        busy;
    logic        scan_done;
    logic [2:0]  rd_ch = 0;
    logic [9:0]  rd_data;
    logic [7:0]  cmp_flags;

    int checks = 0;
    int failures = 0;
    int done_cnt = 0;
    logic [9:0] ana [8];
    logic [9:0] exp_res [8];
    logic       exp_flag [8];
    logic [9:0] cval [8];
    logic       cge [8];

    always #2.5 clk = ~clk;

    sar_scan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .stg_we(stg_we), .stg_en_mask(stg_en_mask),
        .stg_res_bits(stg_res_bits), .stg_continuous(stg_continuous),
        .stg_trig_src(stg_trig_src), .stg_trig_fall(stg_trig_fall),
        .stg_cmp_we(stg_cmp_we), .stg_cmp_ch(stg_cmp_ch), .stg_cmp_val(stg_cmp_val),
        .stg_cmp_ge(stg_cmp_ge), .upd_req(upd_req), .upd_pending(upd_pending),
        .sw_start(sw_start), .trig_in(trig_in), .power_down(power_down),
        .mux_sel(mux_sel), .sample_en(sample_en), .dac_code(dac_code),
        .cmp_in(cmp_in), .busy(busy), .scan_done(scan_done),
        .rd_ch(rd_ch), .rd_data(rd_data), .cmp_flags(cmp_flags)
    );

    // Ideal comparator
    assign cmp_in = (ana[mux_sel] >= dac_code);

    always @(posedge clk) if (rst_n && scan_done) done_cnt++;

    function automatic logic [9:0] expect_conv(input logic [9:0] a, input int r);
        return a & (10'h3FF << (10 - r));
    endfunction

    function automatic int count_en(input logic [7:0] m);
        int n = 0;
        for (int i = 0; i < 8; i++) if (m[i]) n++;
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    task automatic stage_cfg(input logic [7:0] m, input logic [3:0] r, input bit cont,
                             input logic [2:0] src, input bit fall);
        @(negedge clk);
        stg_we = 1; stg_en_mask = m; stg_res_bits = r;
        stg_continuous = cont; stg_trig_src = src; stg_trig_fall = fall;
        @(negedge clk);
        stg_we = 0;
    endtask

    task automatic stage_cmp(input int ch, input logic [9:0] v, input bit ge);
        @(negedge clk);
        stg_cmp_we = 1; stg_cmp_ch = 3'(ch); stg_cmp_val = v; stg_cmp_ge = ge;
        cval[ch] = v; cge[ch] = ge;
        @(negedge clk);
        stg_cmp_we = 0;
    endtask

    task automatic commit();
        @(negedge clk); upd_req = 1;
        @(negedge clk); upd_req = 0;
    endtask

    task automatic start_sw();
        @(negedge clk); sw_start = 1;
        @(negedge clk); sw_start = 0;
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
    endtask

    task automatic update_model(input int r, input logic [7:0] m);
        for (int c = 0; c < 8; c++) if (m[c]) begin
            exp_res[c]  = expect_conv(ana[c], r);
            exp_flag[c] = cge[c] ? (exp_res[c] >= cval[c]) : (exp_res[c] < cval[c]);
        end
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 8; c++) begin
            rd_ch = 3'(c); #0.1;
            chk(rd_data == exp_res[c], {tag, " R1 R13 result"}, rd_data, exp_res[c]);
            chk(cmp_flags[c] == exp_flag[c], {tag, " R8 flag"}, cmp_flags[c], exp_flag[c]);
        end
    endtask

    // Measures one software-started scan; called just after start_sw
    task automatic track_scan(input int r, input logic [7:0] m, input string tag);
        int cyc = 0;
        int nxt = 0;
        bit ord_ok = 1;
        while (busy && cyc < 5000) begin
            if (sample_en) begin
                while (nxt < 8 && !m[nxt]) nxt++;
                if (int'(mux_sel) != nxt) ord_ok = 0;
                nxt++;
            end
            cyc++;
            @(negedge clk);
        end
        chk(cyc == count_en(m) * (1 + r), {tag, " R2 busy cycles"}, cyc, count_en(m) * (1 + r));
        chk(ord_ok, {tag, " R3 channel order"}, ord_ok, 1);
        chk(scan_done == 1'b1, {tag, " R4 done with busy low"}, scan_done, 1);
        @(negedge clk);
        chk(scan_done == 1'b0 && !busy, {tag, " R4 single pulse and stop"}, scan_done, 0);
        update_model(r, m);
        check_all(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int r;
        logic [7:0] m;
        int t1;
        int t2;
        int d0;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 8; c++) begin
            ana[c] = 10'($urandom); exp_res[c] = 0; exp_flag[c] = 0; cval[c] = 0; cge[c] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // Reset state
        chk(!busy && !scan_done && !upd_pending && !sample_en && dac_code == 0 && cmp_flags == 0,
            "reset R4 R10 R12 idle outputs", busy, 0);
        check_all("reset");

        // Random configurations (R1 R2 R3 R4 R8 R13)
        for (int it = 0; it < 12; it++) begin
            r = 2 + int'($urandom % 9);
            m = 8'($urandom % 255 + 1);
            for (int c = 0; c < 8; c++) begin
                ana[c] = 10'($urandom);
                stage_cmp(c, 10'($urandom), bit'($urandom % 2));
            end
            stage_cfg(m, 4'(r), 0, 0, 0);
            commit();
            start_sw();
            track_scan(r, m, "rand");
        end

        // Extremes of input level at full and minimum resolution
        ana[0] = 10'h3FF; ana[7] = 10'h000;
        stage_cmp(0, 10'h3FF, 1); stage_cmp(7, 10'h000, 0);
        stage_cfg(8'h81, 4'd10, 0, 0, 0); commit(); start_sw();
        track_scan(10, 8'h81, "edge R1");

        // Resolution clamp R11
        stage_cfg(8'h05, 4'd0, 0, 0, 0); commit(); start_sw();
        track_scan(2, 8'h05, "clamp low R11");
        stage_cfg(8'h05, 4'd15, 0, 0, 0); commit(); start_sw();
        track_scan(10, 8'h05, "clamp high R11");

        // Staging without update has no effect R9
        stage_cfg(8'h81, 4'd3, 0, 0, 0);
        @(negedge clk);
        chk(!upd_pending, "R9 no pending without request", upd_pending, 0);
        start_sw();
        track_scan(10, 8'h05, "no commit R9");
        commit();
        start_sw();
        track_scan(3, 8'h81, "after commit R9");

        // Update during a scan is deferred R10
        stage_cfg(8'hFF, 4'd6, 0, 0, 0);
        start_sw();
        @(negedge clk); upd_req = 1;
        @(negedge clk); upd_req = 0;
        chk(upd_pending && busy, "R10 pending during scan", upd_pending, 1);
        wait_idle();
        chk(!upd_pending, "R10 pending cleared at scan end", upd_pending, 0);
        update_model(3, 8'h81);
        start_sw();
        track_scan(6, 8'hFF, "deferred R10");

        // Trigger selection R6 and ignore-while-busy R7
        stage_cfg(8'h01, 4'd4, 0, 3'd2, 0); commit();
        @(negedge clk); trig_in[0] = 1;
        repeat (3) @(negedge clk);
        chk(!busy, "R6 unselected line ignored", busy, 0);
        trig_in[1] = 1;
        @(negedge clk);
        chk(busy, "R6 rising edge starts", busy, 0);
        d0 = done_cnt;
        sw_start = 1; trig_in[1] = 0;
        @(negedge clk);
        sw_start = 0; trig_in[1] = 1;
        wait_idle();
        repeat (8) @(negedge clk);
        chk(done_cnt - d0 == 1 && !busy, "R7 starts during scan ignored", done_cnt - d0, 1);
        stage_cfg(8'h01, 4'd4, 0, 3'd2, 1); commit();
        @(negedge clk); trig_in[1] = 0;
        @(negedge clk);
        chk(busy, "R6 falling edge starts", busy, 1);
        wait_idle();
        stage_cfg(8'h01, 4'd4, 0, 3'd0, 0); commit();
        @(negedge clk); trig_in = 4'hF;
        @(negedge clk);
        chk(!busy, "R6 source code 0 ignores lines", busy, 0);
        trig_in = 0;
        update_model(4, 8'h01);

        // Continuous mode R5
        stage_cfg(8'h03, 4'd3, 1, 0, 0); commit(); start_sw();
        for (int k = 0; k < 200 && !scan_done; k++) @(negedge clk);
        t1 = 0;
        @(negedge clk);
        for (int k = 0; k < 200 && !scan_done; k++) begin t1++; @(negedge clk); end
        chk(t1 + 1 == 2 * 4 + 1, "R5 continuous period", t1 + 1, 9);
        stage_cfg(8'h03, 4'd3, 0, 0, 0);
        for (int k = 0; k < 20 && !busy; k++) @(negedge clk);
        upd_req = 1; @(negedge clk); upd_req = 0;
        wait_idle();
        t2 = 0;
        for (int k = 0; k < 20; k++) begin if (busy) t2++; @(negedge clk); end
        chk(t2 == 0, "R5 continuous stopped after update", t2, 0);
        update_model(3, 8'h03);

        // Power-down R12
        stage_cfg(8'h03, 4'd3, 1, 0, 0); commit(); start_sw();
        @(negedge clk);
        power_down = 1;
        @(negedge clk);
        chk(!busy && !sample_en && dac_code == 0, "R12 halted", busy, 0);
        sw_start = 1; @(negedge clk); sw_start = 0; @(negedge clk);
        chk(!busy, "R12 start ignored in power-down", busy, 0);
        power_down = 0;
        repeat (4) @(negedge clk);
        chk(!busy, "R12 no resume after power-down", busy, 0);
        stage_cfg(8'h03, 4'd3, 0, 0, 0); commit();
        check_all("post power-down R13");

        summary();
        $finish;
    end
endmodule